// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block runs the external bus cycles of a small 8-bit controller core. Each bus cycle takes six clocks. In the first two clocks the low address byte is put on a shared address/data port, and an address-latch pulse tells an outside latch to hold it. In the last four clocks the same port carries data. The high address byte sits on a separate port for the whole cycle. Code fetches use a program-store strobe. Data reads and data writes each have their own active-low strobe.

The latch pulse runs all the time, once every six clocks, so a board can use it as a slow clock. The core offers a request with a kind, an address and write data. The block samples that request only on the last clock of a cycle. When the external-only input is low, fetches below the on-chip ROM size are left to the core and produce no bus activity. Idle and power-down inputs, also sampled at the cycle boundary, force the latch pulse and the program-store strobe to fixed levels.

Top module: `xbus_seq`

## Requirements
- R1: After reset `busy`, `rd_valid` and `ad_oe` are low, and `psen_n`, `rd_n` and `wr_n` are high.
- R2: In normal mode `ale` is high for clocks 1–2 of every 6-clock cycle and low for clocks 3–6. During clocks 1–2 of an accepted cycle, `ad_out` carries `req_addr[7:0]` with `ad_oe` high.
- R3: A request is sampled only on the edge that ends clock 6 of a cycle. A `req_valid` pulse that covers no such edge starts no cycle.
- R4: `addr_hi` equals `req_addr[15:8]` of the accepted request from clock 1 through clock 6 of its cycle.
- R5: For a fetch (`req_kind`=0) or a data read (`req_kind`=1), `ad_oe` is low during clocks 3–6. The matching strobe (`psen_n` for a fetch, `rd_n` for a read) is low during clocks 3–5 and high in clock 6.
- R6: Read data is taken from `ad_in` on the edge where the strobe rises. It is shown on `rd_data` with `rd_valid` high for clock 6 only.
- R7: For a data write (`req_kind[1]`=1), `ad_out` carries `req_wdata` with `ad_oe` high during clocks 3–6, and `wr_n` is low during clocks 3–5.
- R8: `psen_n` pulses only for fetches, and `rd_n`/`wr_n` pulse only for data accesses. At most one of the three is low at any time.
- R9: With `ext_only` low, a fetch whose address is below 4096 is ignored: `busy` stays low and `psen_n` stays high. With `ext_only` high, such a fetch runs on the bus.
- R10: In idle (`idle_req` sampled high at a boundary), `ale` and `psen_n` are held high and requests are ignored.
- R11: In power-down (`pdown_req` sampled high at a boundary, taking priority over idle), `ale` and `psen_n` are held low, `rd_n`/`wr_n` are high and requests are ignored.
- R12: `busy` is high for exactly clocks 1–6 of each accepted cycle and rises together with `ale`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_only | input | 1 | High: all fetches go to the external bus |
| idle_req | input | 1 | Idle mode request |
| pdown_req | input | 1 | Power-down mode request |
| req_valid | input | 1 | Core offers a request |
| req_kind | input | 2 | 0 fetch, 1 data read, 2/3 data write |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| ad_in | input | 8 | Shared port, input side |
| busy | output | 1 | Bus cycle in progress |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read or fetched byte |
| ad_out | output | 8 | Shared port, output side |
| ad_oe | output | 1 | Shared port drive enable |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch pulse |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The bench checks the following hard cases:
- A `req_valid` pulse that covers no cycle boundary. A design that samples requests at any time would start an early cycle with `ale` out of step.
- A write followed by a read of the same address. Writing on the wrong clocks, or sampling read data at the strobe fall, would return the stale default byte.
- Fetches below 4096 with `ext_only` low and with it high. A wrong range compare would pulse `psen_n` for on-chip code, or skip an external fetch.
- Idle and power-down with a request held. A design that still accepts would pulse `rd_n`/`wr_n`, and one with swapped levels would show `ale` high in power-down.

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int ROM_BYTES = 4096,
  parameter int CYC       = 6,
  parameter int ALE_CLKS  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_only,
  input  logic          idle_req,
  input  logic          pdown_req,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ad_in,
  output logic          busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] addr_hi,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n
);
  localparam int PW = $clog2(CYC);
  localparam logic [PW-1:0] PH_LAST = PW'(CYC - 1);
  localparam logic [PW-1:0] PH_SEND = PW'(CYC - 2);
  localparam logic [PW-1:0] PH_DATA = PW'(ALE_CLKS);
  localparam logic [AW:0]   ROM_LIM = (AW+1)'(ROM_BYTES);

  logic [PW-1:0] ph;
  logic          act, idle_q, pd_q;
  logic [1:0]    kind;
  logic [AW-1:0] addr;
  logic [DW-1:0] wd, rdq;

  wire last    = (ph == PH_LAST);
  wire addr_ph = (ph < PH_DATA);
  wire is_wr   = kind[1];
  wire win     = act && !addr_ph && !last;
  wire int_hit = (req_kind == 2'd0) && !ext_only && ({1'b0, req_addr} < ROM_LIM);
  wire take    = req_valid && !idle_req && !pdown_req && !int_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= '0; act <= 1'b0; idle_q <= 1'b0; pd_q <= 1'b0;
      kind <= 2'd0; addr <= '0; wd <= '0; rdq <= '0;
    end else begin
      ph <= last ? '0 : ph + 1'b1;
      if (last) begin
        act    <= take;
        idle_q <= idle_req;
        pd_q   <= pdown_req;
        if (take) begin
          kind <= req_kind;
          addr <= req_addr;
          wd   <= req_wdata;
        end
      end
      if (act && !is_wr && ph == PH_SEND) rdq <= ad_in;
    end
  end

  assign ale      = pd_q ? 1'b0 : (idle_q ? 1'b1 : addr_ph);
  assign psen_n   = pd_q ? 1'b0 : !(win && kind == 2'd0);
  assign rd_n     = !(win && kind == 2'd1);
  assign wr_n     = !(win && is_wr);
  assign ad_oe    = act && (addr_ph || is_wr);
  assign ad_out   = addr_ph ? addr[DW-1:0] : wd;
  assign addr_hi  = addr[AW-1:DW];
  assign busy     = act;
  assign rd_valid = act && !is_wr && last;
  assign rd_data  = rdq;

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!rd_n, !wr_n, !psen_n && !pd_q}));
  // R5
  read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || (!psen_n && !pd_q)) |-> !ad_oe);
  // R7
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);
  // R11
  pd_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> (!ale && !psen_n && rd_n && wr_n && !busy));
  // R4
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && ph != '0) |-> $stable(addr_hi));
  // R2
  ale_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale);
  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ale);
endmodule

// File: tb/xbus_seq_tb.sv
`timescale 1ns/1ps
module xbus_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_only = 1'b0, idle_req = 1'b0, pdown_req = 1'b0, req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0] req_wdata = 8'h0, ad_in;
  logic busy, rd_valid, ad_oe, ale, psen_n, rd_n, wr_n;
  logic [7:0] rd_data, ad_out, addr_hi;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  xbus_seq u_dut (.clk(clk), .rst_n(rst_n), .ext_only(ext_only), .idle_req(idle_req),
    .pdown_req(pdown_req), .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .ad_in(ad_in), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n));

  function automatic logic [7:0] code_byte(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // external latch and memories
  logic [7:0] lat = 8'h0;
  logic [7:0] xmem [256];
  initial for (int i = 0; i < 256; i++) xmem[i] = 8'(i + 8'h3C);
  always @(posedge clk) begin
    if (ale) lat <= ad_out;
    if (!wr_n) xmem[lat] <= ad_out;
  end
  always @(*) begin
    if (!psen_n) ad_in = code_byte({addr_hi, lat});
    else if (!rd_n) ad_in = xmem[lat];
    else ad_in = 8'hEE;
  end

  // behavioural reference model
  int mph = 0;
  bit mact = 0, midle = 0, mpd = 0;
  logic [1:0] mk = 2'd0;
  logic [15:0] ma = 16'h0;
  logic [7:0] mw = 8'h0;
  logic [7:0] dmem [256];
  initial for (int i = 0; i < 256; i++) dmem[i] = 8'(i + 8'h3C);

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; mact = 0; midle = 0; mpd = 0;
    end else if (mph == 5) begin
      bit tk;
      if (mact && mk[1]) dmem[ma[7:0]] = mw;
      tk = req_valid && !idle_req && !pdown_req &&
           !(req_kind == 2'd0 && !ext_only && req_addr < 16'd4096);
      mact = tk; midle = idle_req; mpd = pdown_req;
      if (tk) begin mk = req_kind; ma = req_addr; mw = req_wdata; end
      mph = 0;
    end else mph++;
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  bit cmp_on = 0;
  always @(negedge clk) if (cmp_on) begin
    bit win;
    win = mact && mph >= 2 && mph <= 4;
    chk(mpd ? "R11 ale" : midle ? "R10 ale" : "R2 ale", 16'(ale),
        16'(mpd ? 1'b0 : midle ? 1'b1 : (mph < 2)));
    chk(mpd ? "R11 psen_n" : "R8 psen_n", 16'(psen_n), 16'(mpd ? 1'b0 : !(win && mk == 2'd0)));
    chk("R5 rd_n", 16'(rd_n), 16'(!(win && mk == 2'd1)));
    chk("R7 wr_n", 16'(wr_n), 16'(!(win && mk[1])));
    chk("R5 ad_oe", 16'(ad_oe), 16'(mact && (mph < 2 || mk[1])));
    chk("R12 busy", 16'(busy), 16'(mact));
    chk("R6 rd_valid", 16'(rd_valid), 16'(mact && !mk[1] && mph == 5));
    if (mact && mph < 2) chk("R2 ad_out addr", 16'(ad_out), 16'(ma[7:0]));
    if (mact && mph >= 2 && mk[1]) chk("R7 ad_out data", 16'(ad_out), 16'(mw));
    if (mact) chk("R4 addr_hi", 16'(addr_hi), 16'(ma[15:8]));
    if (mact && !mk[1] && mph == 5)
      chk("R6 rd_data", 16'(rd_data), 16'(mk == 2'd0 ? code_byte(ma) : dmem[ma[7:0]]));
  end

  task automatic go(int n); repeat (n) @(negedge clk); #1; endtask

  task automatic do_req(logic [1:0] k, logic [15:0] a, logic [7:0] d);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!(mact && mph == 0));
    #1 req_valid = 1'b0;
    repeat (5) @(negedge clk);
    #1;
  endtask

  task automatic read_expect(logic [1:0] k, logic [15:0] a, logic [7:0] exp, string tag);
    req_valid = 1'b1; req_kind = k; req_addr = a;
    do @(negedge clk); while (!(mact && mph == 0));
    #1 req_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(tag, 16'(rd_data), 16'(exp));
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    go(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 16'(busy), 16'h0);
    chk("R1 strobes", {13'h0, psen_n, rd_n, wr_n}, 16'h7);
    chk("R1 ad_oe", 16'(ad_oe), 16'h0);
    chk("R1 rd_valid", 16'(rd_valid), 16'h0);
    #1 cmp_on = 1;

    // R9 fetch below ROM size with ext_only low is ignored
    req_valid = 1'b1; req_kind = 2'd0; req_addr = 16'h0123;
    repeat (12) begin @(negedge clk); chk("R9 busy", 16'(busy), 16'h0); chk("R9 psen_n", 16'(psen_n), 16'h1); end
    #1 req_valid = 1'b0;

    read_expect(2'd0, 16'h1234, code_byte(16'h1234), "R5 fetch");
    do_req(2'd2, 16'h2040, 8'hA5);
    read_expect(2'd1, 16'h2040, 8'hA5, "R7 write then R6 read");
    read_expect(2'd1, 16'h3077, 8'(8'h77 + 8'h3C), "R6 untouched");
    do_req(2'd3, 16'h4011, 8'h3C);
    read_expect(2'd1, 16'h4011, 8'h3C, "R7 kind3 write");

    ext_only = 1'b1;
    read_expect(2'd0, 16'h0100, code_byte(16'h0100), "R9 ext fetch");
    ext_only = 1'b0;

    // back-to-back reads held valid
    req_valid = 1'b1; req_kind = 2'd1; req_addr = 16'h5A20;
    go(18);
    req_valid = 1'b0;
    go(8);

    // R3 pulse away from boundary
    do @(negedge clk); while (mph != 2);
    #1 req_valid = 1'b1; req_kind = 2'd1; req_addr = 16'h6060;
    @(negedge clk); #1 req_valid = 1'b0;
    repeat (8) begin @(negedge clk); chk("R3 busy", 16'(busy), 16'h0); end
    #1;

    // R10 idle with request held
    idle_req = 1'b1; req_valid = 1'b1; req_kind = 2'd2; req_addr = 16'h7070; req_wdata = 8'h11;
    go(8);
    repeat (6) begin @(negedge clk); chk("R10 ale", 16'(ale), 16'h1); chk("R10 busy", 16'(busy), 16'h0); end
    #1;
    // R11 power-down, over idle
    pdown_req = 1'b1;
    go(8);
    repeat (6) begin @(negedge clk); chk("R11 pins", {14'h0, ale, psen_n}, 16'h0); chk("R11 wr_n", 16'(wr_n), 16'h1); end
    #1;
    idle_req = 1'b0; pdown_req = 1'b0; req_valid = 1'b0;
    go(8);
    read_expect(2'd1, 16'h7070, 8'(8'h70 + 8'h3C), "R11 no write");
    go(6);
    cmp_on = 0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule